// File: doc/BRIEF.md
# Self-Clearing Operand RAM Front End

This block sits in front of a modular arithmetic engine. It holds a word-addressed operand and result memory of 32-bit words. A host reaches that memory, along with a small set of control and status registers, over a single-cycle read/write strobe bus. The host loads operands into the memory, sets the engine running through the control register, waits for the completion interrupt, and reads the results back from the same memory.

When reset is released, the block zeroes the whole memory by itself, writing one word on every clock. While this sweep runs, host memory traffic is suppressed and the engine cannot be enabled. The block also gives the engine a clock enable that is high on every second bus cycle, so the engine logic advances at half the bus rate. The engine itself is not part of this block. A single completion input stands in for it, and the block turns that input into a sticky completion flag and an interrupt.

Top module: `crypto_ram_frontend`

## Requirements
- R1: After reset is released, every one of the WORDS (default 894) memory words is written with zero, one word per clock. Data written before a reset therefore reads back as zero once the sweep has finished.
- R2: Status bit 0 (sweep busy) reads 1 during the first WORDS clocks after reset release and reads 0 from then on.
- R3: While the sweep is busy, a write to control bit 0 (enable) has no effect, so `core_en` stays 0. Control bit 1 (interrupt enable) is still taken from the same write. Once the sweep has finished, control bit 0 drives `core_en`.
- R4: `core_ce` is 0 in the first clock after reset release and toggles on every clock afterwards.
- R5: When bit ADDR_W-1 of the address is 0, address bits ADDR_W-2:0 select a memory word. A read returns the word most recently written at that offset. `bus_rdata` carries the value in the clock after the read strobe and is zero in every clock that does not follow a read.
- R6: If `core_done` is high in a clock where `core_en` is 1, status bit 1 (done) becomes 1. `irq` is high exactly while done is 1 and control bit 1 is 1.
- R7: Writing a word with bit 1 set to the flag-clear register clears done and drops `irq`. A written 0 in bit 1 leaves done as it is. If a completion and a clear arrive in the same clock, the completion wins.
- R8: While the sweep is busy, host writes to the memory window are dropped and host reads of it return zero.
- R9: When address bit ADDR_W-1 is 1, offset 0 is control, offset 1 is status and offset 2 is flag-clear. Every other register offset, and every memory offset at or above WORDS, reads zero and ignores writes. The flag-clear register always reads zero.
- R10: During reset and directly after it, control reads 0, done is 0, `irq` and `core_en` are 0 and `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset; its release starts the memory sweep |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_addr | input | ADDR_W | Word address; the top bit selects the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the clock after `bus_rd` |
| core_done | input | 1 | Completion pulse from the arithmetic engine |
| core_en | output | 1 | Engine run enable (control bit 0) |
| core_ce | output | 1 | Half-rate clock enable for the engine |
| irq | output | 1 | Completion interrupt request |

## Verification
If the sweep pointer or the busy state is wrong, it shows up quickly. The status word read during or just after the 894-clock window is wrong, and a word written before a second reset survives into a read after it, so an off-by-one sweep is visible on the first read of the last word. If the enable lock or the done flag is corrupted, `core_en` or `irq` differs from the bench's reference in the very next clock. The reference is compared on every clock, so a mistimed half-rate enable or a stray nonzero `bus_rdata` is reported in the cycle where it first appears.

// File: rtl/acr_pkg.sv
package acr_pkg;

    localparam int DATA_W = 32;
    typedef logic [DATA_W-1:0] word_t;

    // register window offsets (host visible map)
    localparam int OFF_CTRL = 0;
    localparam int OFF_STAT = 1;
    localparam int OFF_FCLR = 2;

    // bit positions inside the register words
    localparam int BIT_EN   = 0;
    localparam int BIT_IE   = 1;
    localparam int BIT_BUSY = 0;
    localparam int BIT_DONE = 1;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_RAM  = 2'd1,
        SRC_REG  = 2'd2
    } rd_src_e;

    typedef struct packed {
        logic ie;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic done;
        logic busy;
    } stat_t;

    function automatic word_t pack_ctrl(ctrl_t c);
        word_t w;
        w = '0;
        w[BIT_EN] = c.en;
        w[BIT_IE] = c.ie;
        return w;
    endfunction

    function automatic word_t pack_stat(stat_t s);
        word_t w;
        w = '0;
        w[BIT_BUSY] = s.busy;
        w[BIT_DONE] = s.done;
        return w;
    endfunction

endpackage

// File: rtl/acr_sweep.sv
module acr_sweep #(
    parameter int WORDS = 894,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst,
    output logic          busy,
    output logic          clr_we,
    output logic [AW-1:0] clr_addr
);
    localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

    logic          active;
    logic [AW-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b1;
            ptr    <= '0;
        end else if (active) begin
            if (ptr == LAST) begin
                active <= 1'b0;
            end else begin
                ptr <= ptr + 1'b1;
            end
        end
    end

    assign busy     = active;
    assign clr_we   = active;
    assign clr_addr = ptr;

endmodule

// File: rtl/acr_ram.sv
module acr_ram
    import acr_pkg::*;
#(
    parameter int WORDS = 894,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    word_t mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/acr_regs.sv
module acr_regs
    import acr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  busy,
    input  logic  ctrl_we,
    input  logic  fclr_we,
    input  word_t wdata,
    input  logic  core_done,
    output ctrl_t ctrl,
    output logic  done,
    output logic  core_ce,
    output logic  irq
);
    logic set_done;
    logic clr_done;

    assign set_done = core_done && ctrl.en;
    assign clr_done = fclr_we && wdata[BIT_DONE];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (ctrl_we) begin
            ctrl.ie <= wdata[BIT_IE];
            if (!busy) begin
                ctrl.en <= wdata[BIT_EN];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
        end else if (set_done) begin
            done <= 1'b1;
        end else if (clr_done) begin
            done <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_ce <= 1'b0;
        end else begin
            core_ce <= ~core_ce;
        end
    end

    assign irq = done && ctrl.ie;

endmodule

// File: rtl/crypto_ram_frontend.sv
module crypto_ram_frontend
    import acr_pkg::*;
#(
    parameter int WORDS  = 894,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              core_done,
    output logic              core_en,
    output logic              core_ce,
    output logic              irq
);
    localparam int OFF_W  = ADDR_W - 1;
    localparam int RAM_AW = $clog2(WORDS);
    localparam logic [OFF_W-1:0] RAM_TOP = OFF_W'(WORDS);

    // address decode
    logic             win_reg;
    logic [OFF_W-1:0] off;
    logic             ram_hit;
    logic             hit_ctrl;
    logic             hit_stat;
    logic             hit_fclr;

    assign win_reg  = bus_addr[ADDR_W-1];
    assign off      = bus_addr[OFF_W-1:0];
    assign ram_hit  = !win_reg && (off < RAM_TOP);
    assign hit_ctrl = win_reg && (off == OFF_W'(OFF_CTRL));
    assign hit_stat = win_reg && (off == OFF_W'(OFF_STAT));
    assign hit_fclr = win_reg && (off == OFF_W'(OFF_FCLR));

    // sweep
    logic              busy;
    logic              clr_we;
    logic [RAM_AW-1:0] clr_addr;

    acr_sweep #(.WORDS(WORDS), .AW(RAM_AW)) u_sweep (
        .clk      (clk),
        .rst      (rst),
        .busy     (busy),
        .clr_we   (clr_we),
        .clr_addr (clr_addr)
    );

    // memory port arbitration: sweep owns the port while busy
    logic              host_we;
    logic              host_re;
    logic              ram_we;
    logic [RAM_AW-1:0] ram_waddr;
    word_t             ram_wdata;
    word_t             ram_q;

    assign host_we   = bus_wr && ram_hit && !busy;
    assign host_re   = bus_rd && ram_hit && !busy;
    assign ram_we    = clr_we || host_we;
    assign ram_waddr = clr_we ? clr_addr : off[RAM_AW-1:0];
    assign ram_wdata = clr_we ? '0 : bus_wdata;

    acr_ram #(.WORDS(WORDS), .AW(RAM_AW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .re    (host_re),
        .raddr (off[RAM_AW-1:0]),
        .rdata (ram_q)
    );

    // control / status
    ctrl_t ctrl;
    logic  done_q;

    acr_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .ctrl_we   (bus_wr && hit_ctrl),
        .fclr_we   (bus_wr && hit_fclr),
        .wdata     (bus_wdata),
        .core_done (core_done),
        .ctrl      (ctrl),
        .done      (done_q),
        .core_ce   (core_ce),
        .irq       (irq)
    );

    assign core_en = ctrl.en;

    // read path
    word_t   reg_val;
    word_t   reg_q;
    rd_src_e rd_src;
    stat_t   stat;

    assign stat.busy = busy;
    assign stat.done = done_q;

    always_comb begin
        reg_val = '0;
        if (hit_ctrl) begin
            reg_val = pack_ctrl(ctrl);
        end else if (hit_stat) begin
            reg_val = pack_stat(stat);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_src <= SRC_NONE;
            reg_q  <= '0;
        end else begin
            rd_src <= SRC_NONE;
            if (bus_rd && win_reg) begin
                rd_src <= SRC_REG;
                reg_q  <= reg_val;
            end else if (host_re) begin
                rd_src <= SRC_RAM;
            end
        end
    end

    always_comb begin
        case (rd_src)
            SRC_RAM: bus_rdata = ram_q;
            SRC_REG: bus_rdata = reg_q;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/acr_checker.sv
module acr_checker
    import acr_pkg::*;
#(
    parameter int WORDS  = 894,
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              core_done,
    input logic              core_en,
    input logic              core_ce,
    input logic              irq,
    input logic              busy,
    input logic              done_flag
);
    localparam int CNT_W = $clog2(WORDS + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(WORDS);

    logic [CNT_W-1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst < CNT_END) begin
            since_rst <= since_rst + 1'b1;
        end
    end

    logic fclr_hit;
    assign fclr_hit = bus_wr && bus_addr[ADDR_W-1]
                      && (bus_addr[ADDR_W-2:0] == (ADDR_W-1)'(OFF_FCLR))
                      && bus_wdata[BIT_DONE];

    AST_SWEEP_WINDOW: assert property (@(posedge clk) disable iff (rst) busy == (since_rst < CNT_END)); // R2
    AST_EN_LOCKED:    assert property (@(posedge clk) disable iff (rst) busy |-> !core_en); // R3
    AST_CE_FALL:      assert property (@(posedge clk) disable iff (rst) core_ce |=> !core_ce); // R4
    AST_CE_RISE:      assert property (@(posedge clk) disable iff (rst) !core_ce |=> core_ce); // R4
    AST_IDLE_ZERO:    assert property (@(posedge clk) disable iff (rst) !bus_rd |=> bus_rdata == '0); // R5
    AST_DONE_CAUSE:   assert property (@(posedge clk) disable iff (rst) $rose(done_flag) |-> $past(core_done && core_en)); // R6
    AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst) irq |-> done_flag); // R6
    AST_FLAG_CLEAR:   assert property (@(posedge clk) disable iff (rst) (fclr_hit && !core_done) |=> !irq); // R7
    AST_SWEEP_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && busy && !bus_addr[ADDR_W-1]) |=> bus_rdata == '0); // R8

endmodule

bind crypto_ram_frontend acr_checker #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .core_done (core_done),
    .core_en   (core_en),
    .core_ce   (core_ce),
    .irq       (irq),
    .busy      (busy),
    .done_flag (done_q)
);

// File: tb/crypto_ram_frontend_tb.sv
module crypto_ram_frontend_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 894;
    localparam int ADDR_W     = 11;

    logic              clk;
    logic              rst;
    logic              bus_wr;
    logic              bus_rd;
    logic [ADDR_W-1:0] bus_addr;
    logic [31:0]       bus_wdata;
    logic [31:0]       bus_rdata;
    logic              core_done;
    logic              core_en;
    logic              core_ce;
    logic              irq;

    crypto_ram_frontend #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .core_done (core_done),
        .core_en   (core_en),
        .core_ce   (core_ce),
        .irq       (irq)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int    total = 0;
    int    bad   = 0;
    bit    finished = 0;
    string cur_tag = "R10";

    // behavioural reference
    logic [31:0] m_mem [WORDS];
    int          m_ptr;
    bit          m_busy, m_en, m_ie, m_done, m_ce;
    logic [31:0] m_rdata;
    bit          started = 0;

    always @(posedge clk) begin : model
        bit          ob, oe, win;
        int          off;
        logic [31:0] nr;
        started = 1;
        if (rst) begin
            m_busy = 1; m_ptr = 0; m_en = 0; m_ie = 0;
            m_done = 0; m_ce = 0; m_rdata = 0;
        end else begin
            ob  = m_busy;
            oe  = m_en;
            win = bus_addr[ADDR_W-1];
            off = int'(bus_addr[ADDR_W-2:0]);
            nr  = 0;
            if (bus_rd) begin
                if (win) begin
                    if (off == 0) nr = {30'b0, m_ie, m_en};
                    else if (off == 1) nr = {30'b0, m_done, m_busy};
                end else if (!ob && off < WORDS) begin
                    nr = m_mem[off];
                end
            end
            if (bus_wr && !win && !ob && off < WORDS) m_mem[off] = bus_wdata;
            if (ob) begin
                m_mem[m_ptr] = 0;
                if (m_ptr == WORDS-1) m_busy = 0;
                else m_ptr++;
            end
            if (bus_wr && win && off == 0) begin
                m_ie = bus_wdata[1];
                if (!ob) m_en = bus_wdata[0];
            end
            if (core_done && oe) m_done = 1;
            else if (bus_wr && win && off == 2 && bus_wdata[1]) m_done = 0;
            m_ce = !m_ce;
            m_rdata = nr;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string tag, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !finished) begin
            chk(bus_rdata, m_rdata, cur_tag, "bus_rdata");
            chk({31'b0, core_en}, {31'b0, m_en}, "R3", "core_en");
            chk({31'b0, core_ce}, {31'b0, m_ce}, "R4", "core_ce");
            chk({31'b0, irq}, {31'b0, m_done && m_ie}, "R6", "irq");
        end
    end

    function automatic logic [ADDR_W-1:0] ra(input int o);
        return {1'b1, (ADDR_W-1)'(o)};
    endfunction

    function automatic logic [ADDR_W-1:0] ma(input int o);
        return {1'b0, (ADDR_W-1)'(o)};
    endfunction

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        core_done = 1;
        @(negedge clk);
        core_done = 0;
    endtask

    task automatic summary();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin : stim
        rst = 1; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0; core_done = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        // sweep window
        cur_tag = "R2";  rd(ra(1));
        cur_tag = "R3";  wr(ra(0), 32'h3); rd(ra(0));
        cur_tag = "R8";  wr(ma(5), 32'hDEAD_BEEF); rd(ma(5));
        repeat (WORDS) @(negedge clk);
        cur_tag = "R2";  rd(ra(1));
        cur_tag = "R8";  rd(ma(5));
        // every word cleared
        cur_tag = "R1";
        for (int i = 0; i < WORDS; i++) rd(ma(i));
        // plain memory access
        cur_tag = "R5";
        wr(ma(0), 32'h0123_4567);
        wr(ma(WORDS-1), 32'hFEDC_BA98);
        for (int i = 0; i < 16; i++) wr(ma(100 + i), (i * 32'h0101_0101) ^ 32'hA5A5_5A5A);
        rd(ma(0)); rd(ma(WORDS-1));
        for (int i = 0; i < 16; i++) rd(ma(100 + i));
        wr(ma(0), 32'h0);
        rd(ma(0)); rd(ma(1));
        // unmapped space
        cur_tag = "R9";
        wr(ma(WORDS), 32'h1111_1111); wr(ma(1023), 32'h2222_2222);
        rd(ma(WORDS)); rd(ma(1023));
        wr(ra(3), 32'hFFFF_FFFF); rd(ra(3)); rd(ra(2)); rd(ra(0));
        rd(ma(WORDS-1));
        // completion and interrupt
        cur_tag = "R6";
        wr(ra(0), 32'h1);
        pulse_done(); rd(ra(1));
        wr(ra(0), 32'h3); rd(ra(1));
        cur_tag = "R7";
        wr(ra(2), 32'h1); rd(ra(1));
        wr(ra(2), 32'h2); rd(ra(1));
        cur_tag = "R6";
        wr(ra(0), 32'h2); pulse_done(); rd(ra(1));
        cur_tag = "R7";
        wr(ra(0), 32'h3);
        @(negedge clk);
        bus_wr = 1; bus_addr = ra(2); bus_wdata = 32'h2; core_done = 1;
        @(negedge clk);
        bus_wr = 0; core_done = 0;
        rd(ra(1));
        wr(ra(2), 32'hFFFF_FFFF); rd(ra(1));
        // second reset wipes stored data
        cur_tag = "R10";
        wr(ma(7), 32'h1234_5678);
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        rd(ra(0));
        repeat (WORDS + 2) @(negedge clk);
        cur_tag = "R1";
        rd(ma(7)); rd(ma(WORDS-1));
        repeat (2) @(negedge clk);
        summary();
    end

endmodule